// File: doc/BRIEF.md
# Trapezoidal Shaping Threshold Trigger

This block watches one channel of signed 16-bit ADC samples, one sample per clock, and raises a trigger when the signal crosses a programmed level. The block can compare one of two quantities. The first is the raw sample. The second is a trapezoidal shaped value. The shaped value is the difference of two running sums over a window of `P` samples. A gap of `G` samples separates the two windows. A shaped value like this suppresses slow baseline drift and noise before the level comparison.

Two signed levels give hysteresis:
- An arm level starts a trigger.
- A release level must be crossed before the trigger can fire again.

The block produces three outputs:
- A one-clock trigger pulse.
- A gate that stays high while the trigger is armed.
- A copy of the input stream, delayed so that each sample leaves on the same clock as the trigger decision taken on it.

All configuration arrives on parallel input pins.

Top module: `trap_trigger`

## Requirements
- R1: In shaped mode the compared value is `S_new - S_old`. `S_new` is the sum of the newest `P` samples. `S_old` is the sum of the `P` samples that end `P+G` samples before the newest one. `P` is `cfg_peak_i` and must lie in 1..16. `G` is `cfg_gap_i` and must lie in 0..15.
- R2: `cfg_fir_mode_i` = 0 compares the raw sample. `cfg_fir_mode_i` = 1 compares the shaped value of R1.
- R3: `cfg_below_i` = 0 arms when the value is strictly greater than the arm level. `cfg_below_i` = 1 arms when the value is strictly less than it.
- R4: `cfg_thresh_i[15:0]` is the signed arm level. `cfg_thresh_i[31:16]` is the signed release level. Once armed, the trigger disarms only when the value crosses past the release level. For `cfg_below_i` = 0 that means strictly below it. For `cfg_below_i` = 1 that means strictly above it. No new pulse can occur before the trigger has disarmed.
- R5: `trig_o` is high for exactly one clock per arming. `gate_o` rises with the pulse and stays high until the trigger disarms. Both are low during reset and on the first clocks after reset.
- R6: While `cfg_enable_i` is low, `trig_o` and `gate_o` are low and the trigger is disarmed.
- R7: `data_o` equals `sample_i` delayed by 4 clocks, and is zero during reset. The decision on a sample shows on `trig_o` and `gate_o` in the same clock as that sample shows on `data_o`.
- R8: Any change of `cfg_peak_i` or `cfg_gap_i` clears the sample history and both sums. After the change, `trig_o` and `gate_o` stay low until `2P+G` new samples have entered.
- R9: The sums and the shaped value cannot overflow for any legal `P` and `G` with full-scale samples of either sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed ADC sample, one per clock |
| cfg_enable_i | input | 1 | Trigger enable |
| cfg_fir_mode_i | input | 1 | 0 raw sample, 1 shaped value |
| cfg_below_i | input | 1 | 0 fire above arm level, 1 fire below |
| cfg_peak_i | input | 5 | Window length P, 1..16 |
| cfg_gap_i | input | 4 | Gap length G, 0..15 |
| cfg_thresh_i | input | 32 | [15:0] arm level, [31:16] release level, both signed |
| trig_o | output | 1 | One-clock trigger pulse |
| gate_o | output | 1 | High while armed |
| data_o | output | 16 | Input sample delayed by 4 clocks |

## Verification
The ports can show wrong internal state in four ways:
- **Corrupted sum or history.** A wrong running sum or history tap moves the shaped value. The port symptom is a pulse too early, too late, or missing. After a flush this shows within one window of `2P+G` samples. A stuck sum difference persists until the next configuration change.
- **Broken hysteresis.** A hysteresis state that fails to hold gives extra pulses on an oscillating input, within one clock of the second crossing.
- **Missing suppression.** If suppression is missing after a configuration change, a constant input still shows a pulse within the refill window. Zero-padded history makes the shaped value large during that window.
- **Data misalignment.** Any slip in the data delay shows at `data_o` on the very next sample.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic {
    DIR_ABOVE = 1'b0,
    DIR_BELOW = 1'b1
  } trig_dir_e;

  typedef enum logic {
    SRC_RAW = 1'b0,
    SRC_FIR = 1'b1
  } trig_src_e;
endpackage

// File: rtl/trap_sum_line.sv
module trap_sum_line #(
  parameter int DATA_W   = 16,
  parameter int MAX_PEAK = 16,
  parameter int MAX_GAP  = 15,
  parameter int SUM_W    = 22,
  parameter int PW       = 5,
  parameter int GW       = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [PW-1:0]            peak_i,
  input  logic [GW-1:0]            gap_i,
  output logic signed [DATA_W-1:0] newest_o,
  output logic signed [SUM_W-1:0]  trap_o,
  output logic                     ready_o
);
  localparam int DEPTH = 2 * MAX_PEAK + MAX_GAP;
  localparam int IW    = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] PEAK_LIM = IW'(MAX_PEAK);
  localparam logic [IW-1:0] GAP_LIM  = IW'(MAX_GAP);
  localparam logic signed [SUM_W-1:0] TRAP_LIM = SUM_W'(MAX_PEAK * (2 ** DATA_W));

  logic [PW-1:0] peak_q;
  logic [GW-1:0] gap_q;
  logic [IW-1:0] p_eff, g_eff, span, idx_new, idx_mid, idx_old, fill_q;
  logic          flush;
  logic signed [DATA_W-1:0] tap_q [DEPTH];
  logic signed [SUM_W-1:0]  sum_new_q, sum_old_q;

  // window geometry from the captured configuration, clamped to legal range
  always_comb begin
    p_eff = IW'(peak_q);
    if (p_eff == '0)          p_eff = IW'(1);
    else if (p_eff > PEAK_LIM) p_eff = PEAK_LIM;
    g_eff = IW'(gap_q);
    if (g_eff > GAP_LIM) g_eff = GAP_LIM;
    span    = (p_eff << 1) + g_eff;
    idx_new = p_eff - IW'(1);
    idx_mid = p_eff + g_eff - IW'(1);
    idx_old = span - IW'(1);
  end

  assign flush = (peak_i != peak_q) || (gap_i != gap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= PW'(1);
      gap_q  <= '0;
    end else begin
      peak_q <= peak_i;
      gap_q  <= gap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else if (flush) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else begin
      tap_q[0] <= sample_i;
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  // incremental window sums: add entering sample, drop leaving one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_new_q <= '0;
      sum_old_q <= '0;
    end else if (flush) begin
      sum_new_q <= '0;
      sum_old_q <= '0;
    end else begin
      sum_new_q <= sum_new_q + SUM_W'(sample_i) - SUM_W'(tap_q[idx_new]);
      sum_old_q <= sum_old_q + SUM_W'(tap_q[idx_mid]) - SUM_W'(tap_q[idx_old]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             fill_q <= '0;
    else if (flush)          fill_q <= '0;
    else if (fill_q != '1)   fill_q <= fill_q + IW'(1);
  end

  assign newest_o = tap_q[0];
  assign trap_o   = sum_new_q - sum_old_q;
  assign ready_o  = (fill_q >= span);

  assert_flush_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !ready_o);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o <= TRAP_LIM) && (trap_o >= -TRAP_LIM));
endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import trap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SUM_W  = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fir_mode_i,
  input  logic                     below_i,
  input  logic [2*DATA_W-1:0]      thresh_i,
  input  logic signed [DATA_W-1:0] raw_i,
  input  logic signed [SUM_W-1:0]  trap_i,
  input  logic                     ready_i,
  output logic                     on_hit_o,
  output logic                     off_hit_o,
  output logic                     ok_o
);
  logic signed [SUM_W-1:0] val_q, on_lvl, off_lvl;
  logic ok_b_q;

  assign on_lvl  = SUM_W'($signed(thresh_i[DATA_W-1:0]));
  assign off_lvl = SUM_W'($signed(thresh_i[2*DATA_W-1:DATA_W]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      ok_b_q <= 1'b0;
    end else begin
      val_q  <= (trig_src_e'(fir_mode_i) == SRC_FIR) ? trap_i : SUM_W'(raw_i);
      ok_b_q <= ready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_hit_o  <= 1'b0;
      off_hit_o <= 1'b0;
      ok_o      <= 1'b0;
    end else begin
      ok_o <= ok_b_q;
      if (trig_dir_e'(below_i) == DIR_BELOW) begin
        on_hit_o  <= val_q < on_lvl;
        off_hit_o <= val_q > off_lvl;
      end else begin
        on_hit_o  <= val_q > on_lvl;
        off_hit_o <= val_q < off_lvl;
      end
    end
  end

  assert_ready_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $past(ready_i, 2));
endmodule

// File: rtl/trap_hyst.sv
module trap_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic on_hit_i,
  input  logic off_hit_i,
  input  logic ok_i,
  output logic trig_o,
  output logic gate_o
);
  logic armed_q, trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (!enable_i || !ok_i) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (!armed_q && on_hit_i) begin
      armed_q <= 1'b1;
      trig_q  <= 1'b1;
    end else begin
      trig_q <= 1'b0;
      if (armed_q && off_hit_i) armed_q <= 1'b0;
    end
  end

  assign trig_o = trig_q;
  assign gate_o = armed_q;

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);

  assert_pulse_in_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> armed_q);

  assert_enable_gates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!trig_q && !armed_q));
endmodule

// File: rtl/trap_trigger.sv
module trap_trigger #(
  parameter int DATA_W   = 16,
  parameter int MAX_PEAK = 16,
  parameter int MAX_GAP  = 15
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [DATA_W-1:0]                 sample_i,
  input  logic                              cfg_enable_i,
  input  logic                              cfg_fir_mode_i,
  input  logic                              cfg_below_i,
  input  logic [$clog2(MAX_PEAK+1)-1:0]     cfg_peak_i,
  input  logic [$clog2(MAX_GAP+1)-1:0]      cfg_gap_i,
  input  logic [2*DATA_W-1:0]               cfg_thresh_i,
  output logic                              trig_o,
  output logic                              gate_o,
  output logic [DATA_W-1:0]                 data_o
);
  localparam int PW       = $clog2(MAX_PEAK + 1);
  localparam int GW       = $clog2(MAX_GAP + 1);
  localparam int SUM_W    = DATA_W + $clog2(MAX_PEAK) + 2;
  localparam int DATA_DLY = 4;  // fixed by the sum/select/compare/state pipeline

  logic signed [DATA_W-1:0] newest;
  logic signed [SUM_W-1:0]  trap;
  logic ready, on_hit, off_hit, ok;
  logic [DATA_W-1:0] dly_q [DATA_DLY];
  logic [2:0] warm_q;

  trap_sum_line #(
    .DATA_W(DATA_W), .MAX_PEAK(MAX_PEAK), .MAX_GAP(MAX_GAP),
    .SUM_W(SUM_W), .PW(PW), .GW(GW)
  ) i_sum_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i ($signed(sample_i)),
    .peak_i   (cfg_peak_i),
    .gap_i    (cfg_gap_i),
    .newest_o (newest),
    .trap_o   (trap),
    .ready_o  (ready)
  );

  trap_eval #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_eval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fir_mode_i (cfg_fir_mode_i),
    .below_i    (cfg_below_i),
    .thresh_i   (cfg_thresh_i),
    .raw_i      (newest),
    .trap_i     (trap),
    .ready_i    (ready),
    .on_hit_o   (on_hit),
    .off_hit_o  (off_hit),
    .ok_o       (ok)
  );

  trap_hyst i_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (cfg_enable_i),
    .on_hit_i  (on_hit),
    .off_hit_i (off_hit),
    .ok_i      (ok),
    .trig_o    (trig_o),
    .gate_o    (gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DATA_DLY; k++) dly_q[k] <= '0;
    end else begin
      dly_q[0] <= sample_i;
      for (int k = 1; k < DATA_DLY; k++) dly_q[k] <= dly_q[k-1];
    end
  end

  assign data_o = dly_q[DATA_DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
  end

  assert_data_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd4) |-> (data_o == $past(sample_i, 4)));
endmodule

// File: tb/test_trap_trigger.sv
module test_trap_trigger;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic [15:0] sample;
  logic        en, fir, below;
  logic [4:0]  peak;
  logic [3:0]  gap;
  logic [31:0] thresh;
  logic        trig_o, gate_o;
  logic [15:0] data_o;

  trap_trigger i_trap_trigger (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .cfg_enable_i(en), .cfg_fir_mode_i(fir), .cfg_below_i(below),
    .cfg_peak_i(peak), .cfg_gap_i(gap), .cfg_thresh_i(thresh),
    .trig_o(trig_o), .gate_o(gate_o), .data_o(data_o)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  int    trig_cnt = 0;
  bit    cmp_on = 1'b0;
  string phase = "R5";

  // behavioural reference
  int   hist[$];
  int   m_fill, m_peak, m_gap, b_val;
  bit   b_ok, c_on, c_off, c_ok, m_armed, m_trig;
  logic [15:0] m_d [4];

  function automatic int eff_p(int p);
    if (p < 1) return 1;
    if (p > 16) return 16;
    return p;
  endfunction

  function automatic int hist_at(int k);
    if (k < hist.size()) return hist[k];
    return 0;
  endfunction

  function automatic int trap_val(int p, int g);
    int s_new = 0;
    int s_old = 0;
    for (int k = 0; k < p; k++) s_new += hist_at(k);
    for (int k = p + g; k < 2*p + g; k++) s_old += hist_at(k);
    return s_new - s_old;
  endfunction

  always @(posedge clk) begin
    int pe, ge, on_l, off_l;
    if (!rst_n) begin
      hist.delete();
      m_fill = 0; m_peak = 1; m_gap = 0; b_val = 0;
      b_ok = 0; c_on = 0; c_off = 0; c_ok = 0; m_armed = 0; m_trig = 0;
      for (int k = 0; k < 4; k++) m_d[k] = '0;
    end else begin
      // decision state
      if (!en || !c_ok) begin
        m_armed = 0; m_trig = 0;
      end else if (!m_armed && c_on) begin
        m_armed = 1; m_trig = 1;
      end else begin
        m_trig = 0;
        if (m_armed && c_off) m_armed = 0;
      end
      // level comparison
      on_l  = $signed(thresh[15:0]);
      off_l = $signed(thresh[31:16]);
      if (below) begin
        c_on = b_val < on_l; c_off = b_val > off_l;
      end else begin
        c_on = b_val > on_l; c_off = b_val < off_l;
      end
      c_ok = b_ok;
      // value select
      pe = eff_p(m_peak);
      ge = m_gap;
      b_val = fir ? trap_val(pe, ge) : hist_at(0);
      b_ok  = m_fill >= 2*pe + ge;
      // history
      if (int'(peak) != m_peak || int'(gap) != m_gap) begin
        m_peak = int'(peak); m_gap = int'(gap);
        hist.delete();
        m_fill = 0;
      end else begin
        hist.push_front(int'($signed(sample)));
        if (hist.size() > 64) void'(hist.pop_back());
        if (m_fill < 63) m_fill++;
      end
      for (int k = 3; k > 0; k--) m_d[k] = m_d[k-1];
      m_d[0] = sample;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(trig_o == m_trig, $sformatf("R5 [%s]", phase), "trig_o", int'(trig_o), int'(m_trig));
      chk(gate_o == m_armed, $sformatf("R4 [%s]", phase), "gate_o", int'(gate_o), int'(m_armed));
      chk(data_o == m_d[3], $sformatf("R7 [%s]", phase), "data_o", int'(data_o), int'(m_d[3]));
      if (trig_o) trig_cnt++;
    end
  end

  task automatic drive(int v);
    @(negedge clk);
    sample = 16'(v);
  endtask

  task automatic set_thr(int on_l, int off_l);
    thresh = {16'(off_l), 16'(on_l)};
  endtask

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    rst_n = 1'b0; sample = '0; en = 1'b0; fir = 1'b0; below = 1'b0;
    peak = 5'd4; gap = 4'd2; thresh = '0;
    repeat (3) begin
      @(negedge clk);
      chk(trig_o == 1'b0 && gate_o == 1'b0, "R5", "reset trig/gate", int'(trig_o | gate_o), 0);
      chk(data_o == 16'd0, "R7", "reset data", int'(data_o), 0);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R6: disabled, signal far above level
    phase = "R6"; set_thr(100, 50); trig_cnt = 0;
    for (int k = 0; k < 200; k++) drive((k % 50) * 20);
    repeat (5) drive(0);
    chk(trig_cnt == 0, "R6", "pulses while disabled", trig_cnt, 0);

    // R2: raw sample, fire above
    phase = "R2"; en = 1'b1; set_thr(1000, 500);
    for (int k = 0; k < 300; k++) drive(((k * 37) % 2000) - 200);

    // R3: raw sample, fire below
    phase = "R3"; below = 1'b1; set_thr(-1000, -500);
    for (int k = 0; k < 300; k++) drive(200 - ((k * 53) % 2000));

    // R1: shaped value, steps
    phase = "R1"; below = 1'b0; fir = 1'b1; set_thr(2000, 200);
    for (int k = 0; k < 300; k++) drive((((k / 20) % 2) * 800) + (k % 7) * 10);
    peak = 5'd3; gap = 4'd0; set_thr(600, 100);
    for (int k = 0; k < 200; k++) drive((((k / 15) % 2) * 700) - 100);
    // R1: random stream, both modes
    peak = 5'd5; gap = 4'd1; set_thr(4000, -4000);
    for (int k = 0; k < 300; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (k == 150) begin fir = 1'b0; set_thr(12000, -12000); end
      drive(int'(seed[30:15]) - 32768);
    end

    // R4: hysteresis on raw sample
    phase = "R4"; fir = 1'b0; below = 1'b0; set_thr(1000, 500);
    repeat (50) drive(0);
    trig_cnt = 0;
    for (int k = 0; k < 30; k++) drive((k % 2) ? 800 : 1200);
    repeat (10) drive(400);
    repeat (10) drive(1200);
    repeat (20) drive(0);
    chk(trig_cnt == 2, "R4", "pulses across hysteresis", trig_cnt, 2);

    // R8: flush on window change, constant input
    phase = "R8"; fir = 1'b1; set_thr(100, 50);
    repeat (60) drive(3000);
    peak = 5'd8; gap = 4'd5; trig_cnt = 0;
    repeat (40) drive(3000);
    chk(trig_cnt == 0, "R8", "pulses during refill", trig_cnt, 0);
    for (int k = 0; k < 120; k++) drive(((k / 30) % 2) * 3000);

    // R9: full-scale blocks, widest window
    phase = "R9"; peak = 5'd16; gap = 4'd15; set_thr(32767, 0);
    for (int k = 0; k < 240; k++) drive(((k / 60) % 2) ? 32767 : -32768);
    below = 1'b1; set_thr(-32768, 0);
    for (int k = 0; k < 240; k++) drive(((k / 60) % 2) ? -32768 : 32767);

    repeat (8) drive(0);
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL R5 watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule